// File: doc/BRIEF.md
# Byte-wide to dual-edge nibble Ethernet bridge

This block sits between a gigabit MAC that speaks an 8-bit single-data-rate interface and a PHY that speaks a 4-bit interface clocked on both edges. It handles both directions. On the transmit side, each byte and its enable and error flags are spread over four data wires and one control wire. One half of the content goes out while the clock is high, the other while it is low. On the receive side, the two halves are captured on opposite edges and rebuilt into a byte with valid and error flags.

At 1000 Mb/s the clock runs at 125 MHz and every clock carries one full byte. At 100 and 10 Mb/s the clock runs at 25 and 2.5 MHz. In those modes a byte is spread over two clocks, low nibble first, and each nibble is driven on both edges. The `link_gig` input selects the mode. The double-rate edge behaviour is modelled with ordinary rising- and falling-edge registers and a phase mux, with no vendor primitives. The receive clock is expected to be skewed so that it samples in the middle of each half-period.

Top module: `ddr_nibble_bridge`

## Requirements
- R1: While `tx_rst` and `rx_rst` are held high, `ddr_txd_o`, `ddr_txctl_o`, `mac_rxd_o`, `mac_rx_dv_o` and `mac_rx_er_o` all read 0 on both clock phases.
- R2: In gigabit mode, a byte sampled at a rising `tx_clk` edge is placed on `ddr_txd_o` in two halves. Bits [3:0] appear while `tx_clk` is high after that edge, and bits [7:4] appear during the low phase that follows.
- R3: In both modes, `ddr_txctl_o` carries the sampled `mac_tx_en_i` while `tx_clk` is high and the sampled `mac_tx_er_i` while it is low.
- R4: In gigabit mode, the receiver takes the nibble and control bit seen at a rising `rx_clk` edge and the nibble and control bit seen at the following falling edge. At the next rising edge it drives `mac_rxd_o` = {falling nibble, rising nibble}, `mac_rx_dv_o` = the rising control bit and `mac_rx_er_o` = the falling control bit. This happens whatever the valid value is.
- R5: With the DDR outputs looped to the DDR inputs and `rx_clk` lagging `tx_clk` by a quarter period, a byte, enable and error presented on the MAC transmit side appear unchanged on the MAC receive side two `tx_clk` cycles later in gigabit mode.
- R6: In 10/100 mode, a byte is held for two cycles while `mac_tx_en_i` is high. Bits [3:0] go out in the first cycle and bits [7:4] in the second, and each nibble is driven on both phases. Whenever the enable is low, the nibble order restarts at the low nibble.
- R7: In 10/100 mode, the receiver pairs two successive rising-edge nibbles with the control bit high, low nibble first. It raises `mac_rx_dv_o` for exactly one cycle with the assembled byte. `mac_rx_er_o` in that cycle is the OR of the falling-edge control bits of both cycles. A lone nibble followed by a low control bit is discarded, and pairing restarts.
- R8: In 10/100 mode, when the receive control bit is low, `mac_rx_dv_o` and `mac_rx_er_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock (125 / 25 / 2.5 MHz) |
| tx_rst | input | 1 | Synchronous active-high reset, transmit domain |
| link_gig | input | 1 | 1 = gigabit byte-per-clock mode, 0 = 10/100 nibble-per-clock mode |
| mac_txd_i | input | 8 | Transmit byte from the MAC |
| mac_tx_en_i | input | 1 | Transmit enable from the MAC |
| mac_tx_er_i | input | 1 | Transmit error from the MAC, active high |
| ddr_txd_o | output | 4 | Dual-edge transmit nibble to the PHY |
| ddr_txctl_o | output | 1 | Dual-edge transmit control: enable high phase, error low phase |
| rx_clk | input | 1 | Receive clock, skewed to sample mid-phase |
| rx_rst | input | 1 | Synchronous active-high reset, receive domain |
| ddr_rxd_i | input | 4 | Dual-edge receive nibble from the PHY |
| ddr_rxctl_i | input | 1 | Dual-edge receive control: valid high phase, error low phase |
| mac_rxd_o | output | 8 | Rebuilt receive byte |
| mac_rx_dv_o | output | 1 | Receive data valid |
| mac_rx_er_o | output | 1 | Receive error, active high |

## Verification
Some properties are checked in every cycle inside the RTL. In gigabit mode, a sampled rising-edge valid must reach the MAC valid output one edge later, and a clear falling-edge flag must leave the error output low. The transmit enable must reach the high-phase control register. In 10/100 mode, the receive valid must never last two cycles running. The exact wire value in each clock phase, the nibble order and the restart after a lone nibble can only be shown by the bench's directed scenarios. The same holds for the end-to-end loopback latency in each mode.

// File: rtl/ddr_bridge_pkg.sv
package ddr_bridge_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef struct packed {
    logic             ctl;
    logic [NIB_W-1:0] nib;
  } half_t;
endpackage

// File: rtl/ddr_tx_path.sv
module ddr_tx_path
  import ddr_bridge_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gig,
  input  logic [DATA_W-1:0]   byte_i,
  input  logic                en_i,
  input  logic                er_i,
  output logic [DATA_W/2-1:0] pin_d_o,
  output logic                pin_c_o
);
  localparam int HW = DATA_W / 2;

  logic [HW-1:0] lo_n, hi_n, rise_sel, fall_sel;
  logic [HW-1:0] rise_d, fall_hold_d, fall_d;
  logic          rise_c, fall_hold_c, fall_c;
  logic          hi_turn;

  assign lo_n = byte_i[HW-1:0];
  assign hi_n = byte_i[DATA_W-1:HW];

  always_comb begin
    if (gig) begin
      rise_sel = lo_n;
      fall_sel = hi_n;
    end else begin
      rise_sel = hi_turn ? hi_n : lo_n;
      fall_sel = rise_sel;
    end
  end

  // rising-edge launch registers; falling content staged here too
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_d      <= '0;
      rise_c      <= 1'b0;
      fall_hold_d <= '0;
      fall_hold_c <= 1'b0;
      hi_turn     <= 1'b0;
    end else begin
      rise_d      <= rise_sel;
      rise_c      <= en_i;
      fall_hold_d <= fall_sel;
      fall_hold_c <= er_i;
      hi_turn     <= (!gig && en_i) ? ~hi_turn : 1'b0;
    end
  end

  // falling-edge launch registers
  always_ff @(negedge clk) begin
    if (rst) begin
      fall_d <= '0;
      fall_c <= 1'b0;
    end else begin
      fall_d <= fall_hold_d;
      fall_c <= fall_hold_c;
    end
  end

  assign pin_d_o = clk ? rise_d : fall_d;
  assign pin_c_o = clk ? rise_c : fall_c;

  // R3
  en_rise_chk: assert property (@(posedge clk) disable iff (rst)
    en_i |=> rise_c);
  // R6
  nib_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!gig && !en_i) |=> !hi_turn);
endmodule

// File: rtl/ddr_rx_path.sv
module ddr_rx_path
  import ddr_bridge_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gig,
  input  logic [DATA_W/2-1:0] pin_d_i,
  input  logic                pin_c_i,
  output logic [DATA_W-1:0]   byte_o,
  output logic                dv_o,
  output logic                er_o
);
  localparam int HW = DATA_W / 2;

  logic [HW-1:0] rise_d, fall_d, lo_keep;
  logic          rise_c, fall_c, er_keep, hi_next;

  always_ff @(negedge clk) begin
    if (rst) begin
      fall_d <= '0;
      fall_c <= 1'b0;
    end else begin
      fall_d <= pin_d_i;
      fall_c <= pin_c_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_d  <= '0;
      rise_c  <= 1'b0;
      lo_keep <= '0;
      er_keep <= 1'b0;
      hi_next <= 1'b0;
      byte_o  <= '0;
      dv_o    <= 1'b0;
      er_o    <= 1'b0;
    end else begin
      rise_d <= pin_d_i;
      rise_c <= pin_c_i;
      if (gig) begin
        byte_o  <= {fall_d, rise_d};
        dv_o    <= rise_c;
        er_o    <= fall_c;
        hi_next <= 1'b0;
      end else if (rise_c && !hi_next) begin
        lo_keep <= rise_d;
        er_keep <= fall_c;
        hi_next <= 1'b1;
        dv_o    <= 1'b0;
        er_o    <= 1'b0;
      end else if (rise_c) begin
        byte_o  <= {rise_d, lo_keep};
        dv_o    <= 1'b1;
        er_o    <= er_keep | fall_c;
        hi_next <= 1'b0;
      end else begin
        hi_next <= 1'b0;
        dv_o    <= 1'b0;
        er_o    <= 1'b0;
      end
    end
  end

  // R4
  dv_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (gig && rise_c) |=> dv_o);
  // R4
  er_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (gig && !fall_c) |=> !er_o);
  // R7
  slow_dv_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!gig && dv_o) |=> (!dv_o || gig));
endmodule

// File: rtl/ddr_nibble_bridge.sv
module ddr_nibble_bridge
  import ddr_bridge_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic                tx_clk,
  input  logic                tx_rst,
  input  logic                link_gig,
  input  logic [DATA_W-1:0]   mac_txd_i,
  input  logic                mac_tx_en_i,
  input  logic                mac_tx_er_i,
  output logic [DATA_W/2-1:0] ddr_txd_o,
  output logic                ddr_txctl_o,
  input  logic                rx_clk,
  input  logic                rx_rst,
  input  logic [DATA_W/2-1:0] ddr_rxd_i,
  input  logic                ddr_rxctl_i,
  output logic [DATA_W-1:0]   mac_rxd_o,
  output logic                mac_rx_dv_o,
  output logic                mac_rx_er_o
);
  ddr_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk     (tx_clk),
    .rst     (tx_rst),
    .gig     (link_gig),
    .byte_i  (mac_txd_i),
    .en_i    (mac_tx_en_i),
    .er_i    (mac_tx_er_i),
    .pin_d_o (ddr_txd_o),
    .pin_c_o (ddr_txctl_o)
  );

  ddr_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk     (rx_clk),
    .rst     (rx_rst),
    .gig     (link_gig),
    .pin_d_i (ddr_rxd_i),
    .pin_c_i (ddr_rxctl_i),
    .byte_o  (mac_rxd_o),
    .dv_o    (mac_rx_dv_o),
    .er_o    (mac_rx_er_o)
  );
endmodule

// File: tb/tb_ddr_nibble_bridge.sv
module tb_ddr_nibble_bridge;
  localparam int CLK_PERIOD = 8;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int QTR  = CLK_PERIOD / 4;

  logic       tx_clk = 1'b0, rx_clk = 1'b0, rst = 1'b1, link_gig = 1'b1;
  logic [7:0] txd = '0;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] wire_d;
  logic       wire_c;
  logic [7:0] rxd;
  logic       rx_dv, rx_er;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  ddr_nibble_bridge dut (
    .tx_clk(tx_clk), .tx_rst(rst), .link_gig(link_gig),
    .mac_txd_i(txd), .mac_tx_en_i(tx_en), .mac_tx_er_i(tx_er),
    .ddr_txd_o(wire_d), .ddr_txctl_o(wire_c),
    .rx_clk(rx_clk), .rx_rst(rst),
    .ddr_rxd_i(wire_d), .ddr_rxctl_i(wire_c),
    .mac_rxd_o(rxd), .mac_rx_dv_o(rx_dv), .mac_rx_er_o(rx_er)
  );

  initial forever #HALF tx_clk = ~tx_clk;
  initial begin
    #QTR;
    forever #HALF rx_clk = ~rx_clk;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic go_idle(bit gig);
    @(negedge tx_clk);
    tx_en = 0; tx_er = 0; txd = '0; link_gig = gig;
    repeat (4) @(negedge tx_clk);
  endtask

  // R1
  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge tx_clk);
    txd = 8'hFF; tx_en = 1; tx_er = 1;
    @(posedge tx_clk); #1;
    check("R1 txd high phase", wire_d, 0);
    check("R1 txctl high phase", wire_c, 0);
    @(negedge tx_clk); #1;
    check("R1 txd low phase", wire_d, 0);
    check("R1 rx outputs", {rxd, rx_dv, rx_er}, 0);
    tx_en = 0; tx_er = 0; txd = 0;
    @(negedge tx_clk);
    rst = 0;
    repeat (3) @(negedge tx_clk);
  endtask

  // R2, R3 gigabit wire phases
  task automatic t_gig_wire();
    go_idle(1);
    txd = 8'hA5; tx_en = 1; tx_er = 0;
    @(posedge tx_clk); #1;
    check("R2 low nibble high phase", wire_d, 4'h5);
    check("R3 enable high phase", wire_c, 1);
    @(negedge tx_clk); #1;
    check("R2 high nibble low phase", wire_d, 4'hA);
    check("R3 error low phase", wire_c, 0);
    txd = 8'h3C; tx_en = 0; tx_er = 1;
    @(posedge tx_clk); #1;
    check("R2 low nibble high phase b", wire_d, 4'hC);
    check("R3 enable low", wire_c, 0);
    @(negedge tx_clk); #1;
    check("R2 high nibble low phase b", wire_d, 4'h3);
    check("R3 error high", wire_c, 1);
    tx_er = 0;
  endtask

  // R4, R5 gigabit loopback with fixed latency
  task automatic t_gig_loop();
    logic [9:0] seq [8];
    seq[0] = {1'b1, 1'b0, 8'h55}; seq[1] = {1'b1, 1'b0, 8'hD5};
    seq[2] = {1'b1, 1'b0, 8'h00}; seq[3] = {1'b1, 1'b1, 8'hFF};
    seq[4] = {1'b1, 1'b0, 8'h96}; seq[5] = {1'b0, 1'b1, 8'h0F};
    seq[6] = {1'b0, 1'b0, 8'h81}; seq[7] = {1'b1, 1'b0, 8'h7E};
    go_idle(1);
    for (int i = 0; i < 10; i++) begin
      @(negedge tx_clk);
      if (i >= 2) begin
        check("R5 loop byte", rxd, seq[i-2][7:0]);
        check("R4 valid from rising ctl", rx_dv, seq[i-2][9]);
        check("R4 error from falling ctl", rx_er, seq[i-2][8]);
      end
      if (i < 8) {tx_en, tx_er, txd} = seq[i];
      else {tx_en, tx_er, txd} = '0;
    end
  endtask

  // R6, R3 slow-mode wire
  task automatic t_slow_wire();
    go_idle(0);
    txd = 8'h7E; tx_en = 1; tx_er = 1;
    @(posedge tx_clk); #1;
    check("R6 first nibble high phase", wire_d, 4'hE);
    check("R3 slow enable", wire_c, 1);
    @(negedge tx_clk); #1;
    check("R6 first nibble low phase", wire_d, 4'hE);
    check("R3 slow error", wire_c, 1);
    @(posedge tx_clk); #1;
    check("R6 second nibble high phase", wire_d, 4'h7);
    @(negedge tx_clk); #1;
    check("R6 second nibble low phase", wire_d, 4'h7);
    tx_en = 0; tx_er = 0;
  endtask

  // R7 slow loopback, R8 idle
  task automatic t_slow_loop();
    logic [8:0] bs [4];
    bs[0] = {1'b0, 8'h5A}; bs[1] = {1'b1, 8'hC3};
    bs[2] = {1'b0, 8'h01}; bs[3] = {1'b0, 8'hF0};
    go_idle(0);
    check("R8 slow idle dv", rx_dv, 0);
    for (int j = 0; j < 12; j++) begin
      @(negedge tx_clk);
      if (j >= 2 && j <= 9) begin
        if (j % 2 == 1) begin
          check("R7 slow dv", rx_dv, 1);
          check("R7 slow byte", rxd, bs[(j-3)/2][7:0]);
          check("R7 slow error", rx_er, bs[(j-3)/2][8]);
        end else begin
          check("R7 dv single cycle", rx_dv, 0);
        end
      end
      if (j >= 10) check("R8 idle after frame", {rx_dv, rx_er}, 0);
      if (j < 8) begin
        tx_en = 1; tx_er = bs[j/2][8]; txd = bs[j/2][7:0];
      end else begin
        tx_en = 0; tx_er = 0; txd = 8'hEE;
      end
    end
  endtask

  // R6, R7 restart after a lone nibble
  task automatic t_slow_restart();
    go_idle(0);
    for (int j = 0; j < 7; j++) begin
      @(negedge tx_clk);
      if (j >= 2 && j <= 4) check("R7 lone nibble dropped", rx_dv, 0);
      if (j == 5) begin
        check("R6 restart dv", rx_dv, 1);
        check("R6 restart byte", rxd, 8'h96);
      end
      case (j)
        0: begin tx_en = 1; txd = 8'h3C; end
        2, 3: begin tx_en = 1; txd = 8'h96; end
        default: begin tx_en = 0; txd = 8'h00; end
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_gig_wire();
    t_gig_loop();
    t_slow_wire();
    t_slow_loop();
    t_slow_restart();
    go_idle(1);
    finish_run();
  end
endmodule